// File: doc/BRIEF.md
# Waveform Timer-Counter Channel

A single up-counting timer channel with a small register interface, meant to provide a periodic tick, a one-shot delay or a square wave. The channel counts ticks from one of six sources. Four of them are the system clock divided by 2, 8, 32 or 128. The other two are a slow-tick input and an external chained-tick input. Two compare values shape the count and drive a waveform output. An RC match can reload the counter for periodic operation or stop the counting clock for one-shot operation. An RA match, an RC match or a trigger can set, clear or toggle the waveform output.

Software starts the channel through a command register. A trigger from that register, or from the external sync input, zeroes the counter and the prescaler. Event flags are sticky and are cleared when the status register is read. A separate enable register, disable register and read-only mask register decide which flags reach the level interrupt.

Top module: `wave_tc_channel`

## Requirements
- R1: MODE (address 0) bits [2:0] select the tick source. Values 0..3 divide the system clock by 2, 8, 32 and 128, measured from a trigger. Value 4 counts slow_tick pulses and value 5 counts ext_tick pulses. A pulse on the source that is not selected is ignored.
- R2: In free-run mode (MODE bits 3 and 4 clear), the counter wraps from its all-ones value to zero and sets status bit 0 (overflow).
- R3: With MODE bit 3 (reload) set, a tick taken while the count equals RC (address 3) returns the count to zero and sets status bit 2. This gives a period of RC+1 ticks.
- R4: With MODE bit 4 (stop) set, a tick taken while the count equals RC sets status bit 2 and stops the counting clock. The count holds at RC, and the running flag (status bit 16) reads 0.
- R5: A write to CMD (address 1) acts on three bits. Bit 0 enables the counting clock. Bit 1 disables it, and wins when both bits are set. Bit 2 is a trigger that zeroes the counter and the prescaler.
- R6: A one-cycle pulse on sync_in acts exactly like the command trigger.
- R7: Each tio_a action is a 2-bit code: 0 none, 1 set, 2 clear, 3 toggle. MODE[6:5] holds the trigger action, MODE[8:7] the RA (address 2) match action, and MODE[10:9] the RC match action. The trigger action wins over the RC action, and the RC action wins over the RA action.
- R8: Status (address 5) bits 0, 1 and 2 are sticky. A read of status clears them, but an event in the same cycle stays set.
- R9: Writing 1s to IEN (address 6) sets mask bits, and writing 1s to IDIS (address 7) clears them. The mask reads back at address 8.
- R10: irq is high exactly when some sticky status bit has its mask bit set.
- R11: The count value (address 4) is read-only, and a write to it has no effect.
- R12: After reset, the count, status, mask and tio_a are all zero and the counting clock is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | Slow-clock tick, one cycle wide |
| ext_tick | input | 1 | External chained tick, one cycle wide |
| sync_in | input | 1 | External trigger pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears status on address 5) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| tio_a | output | 1 | Waveform output |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume at most one register access per cycle. They also assume that slow_tick, ext_tick and sync_in are synchronous to clk and last one cycle each, except in the overflow run, where ext_tick is held high on purpose. The bench drives every input on the falling edge and issues one write or read at a time. It keeps the tick inputs low between pulses, so no tick goes missing or gets counted twice. Random cases draw the divisor, wait length, RC value and pulse count from a fixed seed. Each expected count, flag and output level is computed from the period rules.

// File: rtl/wave_tc_channel.sv
module wave_tc_channel #(
  parameter int CW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slow_tick,
  input  logic          ext_tick,
  input  logic          sync_in,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          tio_a,
  output logic          irq
);
  localparam logic [AW-1:0] A_MODE = AW'(0), A_CMD = AW'(1), A_RA = AW'(2), A_RC = AW'(3),
                            A_CV = AW'(4), A_STAT = AW'(5), A_IEN = AW'(6), A_IDIS = AW'(7),
                            A_MASK = AW'(8);

  logic [10:0]   mode;
  logic [CW-1:0] ra, rc, cnt;
  logic [6:0]    pre, div_last;
  logic          clk_on;
  logic [2:0]    st, mask, ev;
  logic          wr_cmd, trig, pre_hit, tick, step, hit_rc, hit_ra, hit_ovf, stop_now;
  logic [1:0]    act;
  logic [20:0]   unused_wdata;

  assign unused_wdata = bus_wdata[31:11];
  assign wr_cmd  = bus_wr && bus_addr == A_CMD;
  assign trig    = (wr_cmd && bus_wdata[2]) || sync_in;

  always_comb begin
    case (mode[1:0])
      2'd0:    div_last = 7'd1;
      2'd1:    div_last = 7'd7;
      2'd2:    div_last = 7'd31;
      default: div_last = 7'd127;
    endcase
  end

  assign pre_hit = pre == div_last;

  always_comb begin
    case (mode[2:0])
      3'd0, 3'd1, 3'd2, 3'd3: tick = clk_on && pre_hit;
      3'd4:                   tick = clk_on && slow_tick;
      3'd5:                   tick = clk_on && ext_tick;
      default:                tick = 1'b0;
    endcase
  end

  assign step     = tick && !trig;
  assign hit_rc   = step && cnt == rc;
  assign hit_ra   = step && cnt == ra;
  assign stop_now = hit_rc && mode[4];
  assign hit_ovf  = step && (&cnt) && !(hit_rc && (mode[3] || mode[4]));
  assign ev       = {hit_rc, hit_ra, hit_ovf};

  always_comb begin
    if (trig)        act = mode[6:5];
    else if (hit_rc) act = mode[10:9];
    else if (hit_ra) act = mode[8:7];
    else             act = 2'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0; ra <= '0; rc <= '0; cnt <= '0; pre <= '0;
      clk_on <= 1'b0; st <= '0; mask <= '0; tio_a <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_MODE) mode <= bus_wdata[10:0];
      if (bus_wr && bus_addr == A_RA)   ra   <= bus_wdata[CW-1:0];
      if (bus_wr && bus_addr == A_RC)   rc   <= bus_wdata[CW-1:0];

      if (!clk_on || trig || pre_hit) pre <= '0;
      else                            pre <= pre + 7'd1;

      if (wr_cmd && bus_wdata[1])      clk_on <= 1'b0;
      else if (wr_cmd && bus_wdata[0]) clk_on <= 1'b1;
      else if (stop_now)               clk_on <= 1'b0;

      if (trig)                     cnt <= '0;
      else if (step && !stop_now) cnt <= (hit_rc && mode[3]) ? '0 : cnt + 1'b1;

      case (act)
        2'd1:    tio_a <= 1'b1;
        2'd2:    tio_a <= 1'b0;
        2'd3:    tio_a <= !tio_a;
        default: tio_a <= tio_a;
      endcase

      st <= ((bus_rd && bus_addr == A_STAT) ? 3'b000 : st) | ev;

      if (bus_wr && bus_addr == A_IEN)  mask <= mask | bus_wdata[2:0];
      if (bus_wr && bus_addr == A_IDIS) mask <= mask & ~bus_wdata[2:0];
    end
  end

  assign irq = |(st & mask);

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = {21'd0, mode};
      A_RA:    bus_rdata = 32'(ra);
      A_RC:    bus_rdata = 32'(rc);
      A_CV:    bus_rdata = 32'(cnt);
      A_STAT:  bus_rdata = {15'd0, clk_on, 13'd0, st};
      A_MASK:  bus_rdata = {29'd0, mask};
      default: bus_rdata = 32'd0;
    endcase
  end
endmodule

module wave_tc_channel_chk #(
  parameter int CW = 16,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic [10:0]   mode,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] rc,
  input logic          clk_on,
  input logic          trig,
  input logic          tick,
  input logic [2:0]    mask,
  input logic          irq
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !trig |=> (cnt == $past(cnt) || cnt == CW'($past(cnt) + 1'b1) || cnt == '0)); // R3

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_on && !trig) |=> $stable(cnt)); // R4

  AST_STOP_ON_RC: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !trig && mode[4] && cnt == rc && !(bus_wr && bus_addr == AW'(1)))
    |=> (!clk_on && $stable(cnt))); // R4

  AST_DIS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(1) && bus_wdata[1]) |=> !clk_on); // R5

  AST_TRIG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> cnt == '0); // R6

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mask == 3'b000 |-> !irq); // R10

  AST_IDIS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(7) && (&bus_wdata[2:0])) |=> !irq); // R9
endmodule

bind wave_tc_channel wave_tc_channel_chk #(.CW(CW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .mode(mode), .cnt(cnt), .rc(rc), .clk_on(clk_on), .trig(trig), .tick(tick),
  .mask(mask), .irq(irq)
);

// File: tb/wave_tc_channel_tb_top.sv
`timescale 1ns/1ps
module wave_tc_channel_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, slow_tick = 1'b0, ext_tick = 1'b0, sync_in = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic tio_a, irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wave_tc_channel #(.CW(16), .AW(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .ext_tick(ext_tick), .sync_in(sync_in),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tio_a(tio_a), .irq(irq)
  );

  function automatic logic [31:0] exp_div(input int sel, input int k);
    return 32'(k >> (2 * sel + 1));
  endfunction

  function automatic logic [31:0] exp_period(input int n, input int rcv);
    return 32'(n % (rcv + 1));
  endfunction

  function automatic logic exp_wave(input int n);
    return !(n > 0 && n % 4 == 0);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_ext();
    ext_tick = 1'b1; @(negedge clk); ext_tick = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_slow();
    slow_tick = 1'b1; @(negedge clk); slow_tick = 1'b0; @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_up();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(4'd4, d); check("R12 count", d, 0);
    rd(4'd5, d); check("R12 status", d, 0);
    rd(4'd8, d); check("R12 mask", d, 0);
    check("R12 tio_a", 32'(tio_a), 0);
    check("R12 irq", 32'(irq), 0);

    // R1 prescaled sources, random divisor and wait
    for (int i = 0; i < 8; i++) begin
      int sel = int'($urandom % 4);
      int k = int'($urandom % 300);
      wr(4'd0, 32'(sel));
      wr(4'd1, 32'h5);
      repeat (k) @(negedge clk);
      rd(4'd4, d); check("R1 prescale", d, exp_div(sel, k));
      wr(4'd1, 32'h2);
    end

    // R1 slow source, ext ignored
    wr(4'd0, 32'd4); wr(4'd1, 32'h5);
    repeat (6) pulse_slow();
    rd(4'd4, d); check("R1 slow", d, 6);
    repeat (3) pulse_ext();
    rd(4'd4, d); check("R1 other source ignored", d, 6);

    // R5 command bits
    wr(4'd1, 32'h2);
    repeat (3) pulse_slow();
    rd(4'd4, d); check("R5 disabled holds", d, 6);
    rd(4'd5, d); check("R5 running clear", d & 32'h10000, 0);
    wr(4'd1, 32'h1);
    repeat (2) pulse_slow();
    rd(4'd4, d); check("R5 enable keeps count", d, 8);
    wr(4'd1, 32'h3);
    rd(4'd5, d); check("R5 disable wins", d & 32'h10000, 0);

    // R6 sync
    sync_in = 1'b1; @(negedge clk); sync_in = 1'b0;
    rd(4'd4, d); check("R6 sync zeroes", d, 0);

    // R3 periodic, random RC and pulse counts
    for (int i = 0; i < 4; i++) begin
      int rcv = 1 + int'($urandom % 6);
      int n = int'($urandom % 20);
      wr(4'd0, 32'd5 | (1 << 3));
      wr(4'd2, 32'hFFFF);
      wr(4'd3, 32'(rcv));
      wr(4'd1, 32'h5);
      rd(4'd5, d);
      repeat (n) pulse_ext();
      rd(4'd4, d); check("R3 periodic count", d, exp_period(n, rcv));
      rd(4'd5, d); check("R3 rc flag", (d >> 2) & 1, 32'(n > rcv));
    end

    // R4 one-shot
    wr(4'd0, 32'd5 | (1 << 4)); wr(4'd2, 32'd0); wr(4'd3, 32'd5);
    wr(4'd1, 32'h5); rd(4'd5, d);
    repeat (9) pulse_ext();
    rd(4'd4, d); check("R4 holds at RC", d, 5);
    rd(4'd5, d); check("R4 stopped with flags", d, 32'h6);

    // R7 waveform: trigger set, RA set, RC clear
    wr(4'd0, 32'd5 | (1 << 3) | (1 << 5) | (1 << 7) | (2 << 9));
    wr(4'd2, 32'd0); wr(4'd3, 32'd3);
    wr(4'd1, 32'h5);
    check("R7 trigger sets", 32'(tio_a), 1);
    for (int n = 1; n <= 8; n++) begin
      pulse_ext();
      check("R7 wave level", 32'(tio_a), 32'(exp_wave(n)));
    end
    wr(4'd2, 32'd2); wr(4'd3, 32'd2);
    wr(4'd1, 32'h5);
    repeat (3) pulse_ext();
    check("R7 RC over RA", 32'(tio_a), 0);
    wr(4'd0, 32'd5 | (3 << 5));
    wr(4'd1, 32'h4);
    check("R7 trigger toggle", 32'(tio_a), 1);

    // R9 R10 R8 interrupts
    wr(4'd0, 32'd5 | (1 << 3)); wr(4'd2, 32'hFFFF); wr(4'd3, 32'd1);
    wr(4'd1, 32'h5); rd(4'd5, d);
    wr(4'd6, 32'h4);
    rd(4'd8, d); check("R9 mask set", d, 4);
    check("R10 no event no irq", 32'(irq), 0);
    repeat (2) pulse_ext();
    repeat (4) @(negedge clk);
    check("R8 R10 sticky irq", 32'(irq), 1);
    rd(4'd5, d); check("R8 flag seen", (d >> 2) & 1, 1);
    check("R8 read clears", 32'(irq), 0);
    rd(4'd5, d); check("R8 cleared", d & 32'h7, 0);
    repeat (2) pulse_ext();
    wr(4'd7, 32'h7);
    rd(4'd8, d); check("R9 mask cleared", d, 0);
    check("R10 masked irq low", 32'(irq), 0);

    // R11 count read-only
    wr(4'd1, 32'h2);
    rd(4'd4, d);
    wr(4'd4, 32'h1234);
    begin
      logic [31:0] d2;
      rd(4'd4, d2); check("R11 write ignored", d2, d);
    end

    // R2 overflow
    wr(4'd0, 32'd5); wr(4'd2, 32'h0); wr(4'd3, 32'h0);
    wr(4'd1, 32'h5); rd(4'd5, d);
    ext_tick = 1'b1;
    repeat (65536) @(negedge clk);
    ext_tick = 1'b0;
    rd(4'd4, d); check("R2 wrap to zero", d, 0);
    rd(4'd5, d); check("R2 overflow flag", d & 1, 1);

    finish_up();
  end
endmodule